// File: doc/BRIEF.md
# Trace Capture Buffer Controller

The block records 32-bit trace frames in an on-chip circular memory while capture is switched on, and lets a debug host read them back through a narrow register port. Each register access carries a 32-bit data word, a 7-bit register address and a direction bit (0 reads, 1 writes). The value fetched by a read appears on the read-data output after the access's clock edge, in time for the host to shift it out during its next access. The data register at address 4 therefore yields a new memory entry on every read, because each such read moves the read pointer forward. The host must end a readout with a harmless address (for example 0) so that no extra entry is consumed.

A trigger input arms a post-trigger countdown. Once the trigger has been seen, every stored frame lowers the count by one. When the count reaches zero, acquisition is reported complete and the memory is frozen, so the memory holds a chosen share of frames before and after the event. The write pointer wraps modulo the memory depth. A sticky flag records that a wrap has happened: when it is set, the oldest frame sits at the write pointer; when it is clear, the valid frames run from 0 up to one below the write pointer.

The register map is: 0 identification, 1 depth, 2 frame width, 3 status, 4 memory data, 5 read pointer, 6 write pointer, 7 post-trigger count, 8 control.

Top module: `trace_capture_buf`

## Requirements
- R1: A read access (direction 0) places the addressed register's value on `acc_rdata` after that access's clock edge, and the value is held until the next read. A write access (direction 1) loads the addressed writable register.
- R2: Address 0 reads the ID_VALUE parameter, address 1 reads DEPTH and address 2 reads 32. Writes to these three addresses have no effect.
- R3: Addresses 9 to 127 read as zero, and writes to them have no effect.
- R4: Capture is on while control bit 0 (address 8) is 1. A frame offered on `trc_valid` is then stored at the write pointer, and the pointer moves on by one. When bit 0 is 0, offered frames are dropped and the write pointer holds.
- R5: A read of address 4 returns the memory entry at the read pointer and advances the read pointer by one, modulo DEPTH. Reads of other addresses leave the read pointer unchanged.
- R6: When a frame is stored at write pointer DEPTH-1, the pointer becomes 0 and status bit 0 (Full) is set. Full stays set until cleared under R10.
- R7: A `trc_trigger` pulse while capture is on sets status bit 1 (Triggered). After that, each stored frame lowers the count at address 7 by one; frames stored before the trigger leave the count unchanged. When the count is zero, status bit 2 (Complete) is set and no further frames are stored.
- R8: Status bit 3 (formatter empty) is 1 when no offered frame is waiting in the input stage, and 0 while frames are arriving every cycle.
- R9: Writing address 5 or address 6 sets the read pointer or the write pointer to the written value modulo DEPTH.
- R10: Writing control with bit 0 set while capture is off clears Full, Triggered and Complete.
- R11: Control bit 1 (demultiplexed port mode) can be stored only when TRACE_PORT_BITS is 8. For any other TRACE_PORT_BITS value it reads as 0.
- R12: After reset, both pointers, the count and control are 0, and status reads 8 (only formatter-empty set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | A trace frame is offered this cycle |
| trc_data | input | 32 | Trace frame |
| trc_trigger | input | 1 | Trigger event pulse |
| acc_valid | input | 1 | Register access this cycle |
| acc_wdata | input | 32 | Access data field |
| acc_addr | input | 7 | Access register address |
| acc_write | input | 1 | Direction: 1 write, 0 read |
| acc_rdata | output | 32 | Result of the most recent read access |

## Verification
A read result is ready one edge after the access. The bench drives each access for exactly one cycle from a falling edge and samples `acc_rdata` at the next falling edge. An offered frame passes through the input stage, so the write pointer and memory change on the second rising edge after `trc_valid`. Each frame task therefore waits one extra falling edge before any check. Triggered is set one edge after the pulse, and Complete is set one edge after the count reaches zero; both are read back only after their frame tasks have completed.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int unsigned REG_AW    = 7;
  localparam int unsigned FRAME_W   = 32;

  localparam logic [REG_AW-1:0] RA_IDENT  = 7'd0;
  localparam logic [REG_AW-1:0] RA_DEPTH  = 7'd1;
  localparam logic [REG_AW-1:0] RA_WIDTH  = 7'd2;
  localparam logic [REG_AW-1:0] RA_STATUS = 7'd3;
  localparam logic [REG_AW-1:0] RA_DATA   = 7'd4;
  localparam logic [REG_AW-1:0] RA_RDPTR  = 7'd5;
  localparam logic [REG_AW-1:0] RA_WRPTR  = 7'd6;
  localparam logic [REG_AW-1:0] RA_TCOUNT = 7'd7;
  localparam logic [REG_AW-1:0] RA_CTRL   = 7'd8;

  localparam int unsigned CT_EN    = 0;
  localparam int unsigned CT_DEMUX = 1;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcb_ptrs.sv
module tcb_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          store,
  input  logic          rp_adv,
  input  logic          wp_load,
  input  logic          rp_load,
  input  logic [31:0]   load_val,
  input  logic          clr_full,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0] load_mod;
  assign load_mod = AW'(load_val % 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst)            wr_ptr <= '0;
    else if (wp_load)   wr_ptr <= load_mod;
    else if (store)     wr_ptr <= step(wr_ptr);
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_ptr <= '0;
    else if (rp_load)   rd_ptr <= load_mod;
    else if (rp_adv)    rd_ptr <= step(rd_ptr);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_full)                          full <= 1'b0;
    else if (store && !wp_load && wr_ptr == LAST) full <= 1'b1;
  end

  AST_WP_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(wr_ptr) < DEPTH && 32'(rd_ptr) < DEPTH); // R6
  AST_WRAP_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    store && !wp_load && !clr_full && wr_ptr == LAST |=> full && wr_ptr == '0); // R6
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    full && !clr_full |=> full); // R6
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    rp_adv && !rp_load |=> rd_ptr == step($past(rd_ptr))); // R5
endmodule

// File: rtl/tcb_trig.sv
module tcb_trig (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        trig_in,
  input  logic        store,
  input  logic        clr,
  input  logic        cnt_load,
  input  logic [31:0] load_val,
  output logic        triggered,
  output logic        done,
  output logic        halt,
  output logic [31:0] cnt
);
  logic cnt_zero;
  assign cnt_zero = (cnt == '0);
  assign halt     = done || (triggered && cnt_zero);

  always_ff @(posedge clk) begin
    if (rst)                                   cnt <= '0;
    else if (cnt_load)                         cnt <= load_val;
    else if (store && triggered && !cnt_zero)  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                   triggered <= 1'b0;
    else if (en && trig_in && !done)  triggered <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                         done <= 1'b0;
    else if (en && triggered && cnt_zero)   done <= 1'b1;
  end

  AST_DONE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (rst)
    done |-> triggered); // R7
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
    !cnt_load && store && triggered && !cnt_zero |=> cnt == $past(cnt) - 1); // R7
  AST_CNT_HOLD_PRE: assert property (@(posedge clk) disable iff (rst)
    !cnt_load && !triggered |=> cnt == $past(cnt)); // R7
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH           = 16,
  parameter logic [31:0] ID_VALUE        = 32'h7C0B_0001,
  parameter int unsigned TRACE_PORT_BITS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  input  logic        trc_trigger,
  input  logic        acc_valid,
  input  logic [31:0] acc_wdata,
  input  logic [6:0]  acc_addr,
  input  logic        acc_write,
  output logic [31:0] acc_rdata
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic wr_acc, rd_acc;
  assign wr_acc = acc_valid && acc_write;
  assign rd_acc = acc_valid && !acc_write;

  logic ctrl_en, ctrl_demux;
  logic clr_flags;
  assign clr_flags = wr_acc && acc_addr == RA_CTRL && acc_wdata[CT_EN] && !ctrl_en;

  always_ff @(posedge clk) begin
    if (rst)                            ctrl_en <= 1'b0;
    else if (wr_acc && acc_addr == RA_CTRL) ctrl_en <= acc_wdata[CT_EN];
  end

  generate
    if (TRACE_PORT_BITS == 8) begin : g_demux
      always_ff @(posedge clk) begin
        if (rst)                            ctrl_demux <= 1'b0;
        else if (wr_acc && acc_addr == RA_CTRL) ctrl_demux <= acc_wdata[CT_DEMUX];
      end
    end else begin : g_no_demux
      assign ctrl_demux = 1'b0;
    end
  endgenerate

  // input stage: one frame in flight between the trace port and memory
  logic               halt;
  logic               stage_v;
  logic [FRAME_W-1:0] stage_d;
  logic               store;

  always_ff @(posedge clk) begin
    if (rst) stage_v <= 1'b0;
    else     stage_v <= trc_valid && ctrl_en && !halt;
  end

  always_ff @(posedge clk) begin
    if (trc_valid) stage_d <= trc_data;
  end

  assign store = stage_v && ctrl_en && !halt;

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, triggered, done;
  logic [31:0]   tcount;
  logic          data_rd;
  assign data_rd = rd_acc && acc_addr == RA_DATA;

  tcb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .store    (store),
    .rp_adv   (data_rd),
    .wp_load  (wr_acc && acc_addr == RA_WRPTR),
    .rp_load  (wr_acc && acc_addr == RA_RDPTR),
    .load_val (acc_wdata),
    .clr_full (clr_flags),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .full     (full)
  );

  tcb_trig u_trig (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_en),
    .trig_in   (trc_trigger),
    .store     (store),
    .clr       (clr_flags),
    .cnt_load  (wr_acc && acc_addr == RA_TCOUNT),
    .load_val  (acc_wdata),
    .triggered (triggered),
    .done      (done),
    .halt      (halt),
    .cnt       (tcount)
  );

  logic [FRAME_W-1:0] ram_q;

  tcb_ram #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_ram (
    .clk   (clk),
    .we    (store),
    .waddr (wr_ptr),
    .wdata (stage_d),
    .re    (data_rd),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  // read path: register value captured at the access edge
  logic [31:0] status_w, reg_mux;
  assign status_w = {28'd0, !stage_v, done, triggered, full};

  always_comb begin
    case (acc_addr)
      RA_IDENT:  reg_mux = ID_VALUE;
      RA_DEPTH:  reg_mux = 32'(DEPTH);
      RA_WIDTH:  reg_mux = 32'(FRAME_W);
      RA_STATUS: reg_mux = status_w;
      RA_RDPTR:  reg_mux = 32'(rd_ptr);
      RA_WRPTR:  reg_mux = 32'(wr_ptr);
      RA_TCOUNT: reg_mux = tcount;
      RA_CTRL:   reg_mux = {30'd0, ctrl_demux, ctrl_en};
      default:   reg_mux = 32'd0;
    endcase
  end

  logic [31:0] reg_q;
  logic        sel_ram;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      sel_ram <= 1'b0;
    end else if (rd_acc) begin
      reg_q   <= reg_mux;
      sel_ram <= (acc_addr == RA_DATA);
    end
  end

  assign acc_rdata = sel_ram ? ram_q : reg_q;

  AST_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en && !(wr_acc && acc_addr == RA_WRPTR) |=> $stable(wr_ptr)); // R4
  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done && !(wr_acc && acc_addr == RA_WRPTR) |=> $stable(wr_ptr)); // R7
  AST_RDPTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !data_rd && !(wr_acc && acc_addr == RA_RDPTR) |=> $stable(rd_ptr)); // R5
endmodule

// File: tb/test_trace_capture_buf.sv
module test_trace_capture_buf;
  localparam int unsigned DEPTH = 16;
  localparam logic [31:0] IDV   = 32'h7C0B_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trc_valid = 1'b0;
  logic [31:0] trc_data = '0;
  logic        trc_trigger = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [6:0]  acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_rdata, acc_rdata_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .ID_VALUE(IDV), .TRACE_PORT_BITS(8)) i_trace_capture_buf (
    .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger),
    .acc_valid(acc_valid), .acc_wdata(acc_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_rdata(acc_rdata));

  trace_capture_buf #(.DEPTH(DEPTH), .ID_VALUE(IDV), .TRACE_PORT_BITS(4)) i_tcb_narrow (
    .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger),
    .acc_valid(acc_valid), .acc_wdata(acc_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_rdata(acc_rdata_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_wdata = '0;
    @(negedge clk);
    acc_valid = 1'b0;
    v = acc_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    trc_valid = 1'b1; trc_data = d;
    @(negedge clk);
    trc_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_trigger();
    @(negedge clk); trc_trigger = 1'b1;
    @(negedge clk); trc_trigger = 1'b0;
  endtask

  task automatic restart();
    wr(7'd8, 32'd0);
    wr(7'd8, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(7'd3, v); check("R12 status", v, 32'd8);
    rd(7'd5, v); check("R12 rdptr", v, 0);
    rd(7'd6, v); check("R12 wrptr", v, 0);
    rd(7'd7, v); check("R12 count", v, 0);
    rd(7'd8, v); check("R12 ctrl", v, 0);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    wr(7'd0, 32'hFFFF_FFFF); wr(7'd1, 32'd3); wr(7'd2, 32'd5);
    rd(7'd0, v); check("R2 ident", v, IDV);
    rd(7'd1, v); check("R2 depth", v, DEPTH);
    rd(7'd2, v); check("R2 width", v, 32);
    wr(7'd9, 32'h1234_5678); wr(7'd127, 32'hFFFF_FFFF);
    rd(7'd9, v);   check("R3 unmapped 9", v, 0);
    rd(7'd127, v); check("R3 unmapped 127", v, 0);
    rd(7'd8, v);   check("R3 ctrl untouched", v, 0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr(7'd8, 32'd1);
    rd(7'd8, v); check("R1 ctrl write/read", v, 1);
    push(32'hA000_0001); push(32'hA000_0002); push(32'hA000_0003);
    rd(7'd6, v); check("R4 wrptr after 3", v, 3);
    wr(7'd5, 32'd0);
    rd(7'd4, v); check("R5 data 0", v, 32'hA000_0001);
    rd(7'd3, v); // status read must not advance
    rd(7'd4, v); check("R5 data 1", v, 32'hA000_0002);
    rd(7'd4, v); check("R5 data 2", v, 32'hA000_0003);
    rd(7'd0, v); check("R1 final ident read", v, IDV);
    rd(7'd5, v); check("R5 rdptr after 3 data reads", v, 3);
    wr(7'd8, 32'd0);
    push(32'hDEAD_0000);
    rd(7'd6, v); check("R4 disabled keeps wrptr", v, 3);
  endtask

  task automatic t_ptr_load();
    logic [31:0] v;
    wr(7'd5, 32'd17); rd(7'd5, v); check("R9 rdptr mod", v, 1);
    wr(7'd6, 32'd35); rd(7'd6, v); check("R9 wrptr mod", v, 3);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    restart();
    wr(7'd6, DEPTH - 2);
    push(32'hB000_000E); push(32'hB000_000F);
    rd(7'd6, v); check("R6 wrptr wrapped", v, 0);
    rd(7'd3, v); check("R6 full set", v, 32'd9);
    wr(7'd5, DEPTH - 1);
    rd(7'd4, v); check("R5 last entry", v, 32'hB000_000F);
    rd(7'd5, v); check("R5 rdptr wraps", v, 0);
    restart();
    rd(7'd3, v); check("R10 flags cleared", v, 32'd8);
  endtask

  task automatic t_fempty();
    logic [31:0] v;
    restart();
    @(negedge clk); trc_valid = 1'b1; trc_data = 32'h5555_0000;
    rd(7'd3, v);
    trc_valid = 1'b0;
    check("R8 stage busy", {28'd0, v[3:0]} & 32'h8, 0);
    @(negedge clk); @(negedge clk);
    rd(7'd3, v); check("R8 stage empty", v & 32'h8, 32'h8);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    restart();
    wr(7'd6, 32'd0);
    wr(7'd7, 32'd3);
    push(32'hC000_0000); push(32'hC000_0001);
    rd(7'd7, v); check("R7 count held before trigger", v, 3);
    pulse_trigger();
    rd(7'd3, v); check("R7 triggered", v, 32'hA);
    push(32'hC000_0002); push(32'hC000_0003); push(32'hC000_0004);
    push(32'hC000_0005); push(32'hC000_0006);
    rd(7'd6, v); check("R7 stored stops", v, 5);
    rd(7'd7, v); check("R7 count zero", v, 0);
    rd(7'd3, v); check("R7 complete", v, 32'hE);
    wr(7'd5, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(7'd4, v); check("R7 readback", v, 32'hC000_0000 + 32'(i));
    end
  endtask

  task automatic t_demux();
    wr(7'd8, 32'd3);
    @(negedge clk); acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 7'd8;
    @(negedge clk); acc_valid = 1'b0;
    check("R11 demux kept (8-bit)", acc_rdata, 3);
    check("R11 demux dropped (4-bit)", acc_rdata_n, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_capture();
    t_ptr_load();
    t_wrap();
    t_fempty();
    t_trigger();
    t_demux();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule